// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block stands between a programming port and the configuration state of a small logic device. It accepts one command at a time over a valid/ready handshake. Each command carries an opcode, an address and a data byte. It writes or reads back configuration words, forces the output registers to chosen values, sets a one-time lock, writes or reads an eight-byte user signature, and erases the whole configuration. Every command finishes with a one-cycle done pulse. The response data and a blocked flag are valid during that pulse.

The lock bit decides what the port may do. Once the lock is set, configuration readback returns zeros and raises the blocked flag, and output-register preload is refused with the same flag. The lock acts on the command that sets it, so the very next readback is already refused. The signature stays readable and writable whether or not the lock is set. Only the erase command releases the lock, and that erase also zeroes every configuration word. The configuration store and the signature are modelled as register arrays.

The sequencer has four states:
- IDLE: the command port is ready.
- EXEC: the captured command is carried out.
- ERASE: one configuration word is cleared per cycle.
- RESP: the done pulse is driven.

Its transitions are:
- IDLE to EXEC on an accepted command.
- EXEC to ERASE for the erase opcode.
- EXEC to RESP for every other opcode.
- ERASE to RESP after the last word is cleared.
- RESP to IDLE always.

Top module: `cfg_guard`

## Requirements
- R1: `cmd_ready` is high only in IDLE. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. For every opcode except erase, `done` is high for exactly one cycle, starting at the first rising edge after the accepting edge. `cmd_ready` is low during that cycle and high again in the next one.
- R2: The opcode encoding is: 0 config write, 1 config verify, 2 preload, 3 lock, 4 signature write, 5 signature read, 6 erase, 7 reserved. While unlocked, config write stores `cmd_data` at word `cmd_addr`. A later verify of that address returns the stored word on `rsp_data` with `rsp_blocked` low.
- R3: The lock opcode sets the lock. `secured` reads 1 in the done cycle of that command. A verify accepted directly after it is already blocked.
- R4: A verify while locked completes on the normal schedule. It returns `rsp_data` = 0 and `rsp_blocked` = 1.
- R5: A preload while unlocked sets each bit of `outreg_q` to the matching bit of `cmd_data`, independently. The new value is visible in the done cycle, with `rsp_blocked` low.
- R6: A preload while locked leaves `outreg_q` unchanged and returns `rsp_blocked` = 1.
- R7: Signature write stores `cmd_data` in byte `cmd_addr[2:0]`. Signature read returns that byte with `rsp_blocked` low, whether locked or not.
- R8: Erase sets every configuration word to zero and clears the lock. `done` starts CFG_WORDS+1 rising edges after the accepting edge. `secured` stays 1 until the done cycle. The signature bytes and `outreg_q` are kept.
- R9: The reserved opcode completes on the normal schedule with `rsp_data` = 0 and `rsp_blocked` = 0. It changes no state.
- R10: After reset, `cmd_ready` = 1, `done` = 0, `secured` = 0, `outreg_q` = 0, `rsp_data` = 0, and every configuration word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | $clog2(CFG_WORDS) | Config word index, or signature byte index in the low bits |
| cmd_data | input | DATA_W | Write or preload data |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Read result, valid with `done`, zero otherwise |
| rsp_blocked | output | 1 | Command refused by the lock, valid with `done` |
| secured | output | 1 | Lock state |
| outreg_q | output | NUM_REGS | Output register values |

## Verification
Two functions can fall in the same cycle: the done pulse of a lock command, and the valid of the verify that follows it. The bench raises `cmd_valid` for the verify during the lock's done cycle and holds it until the controller returns to IDLE. The verify then runs with no idle gap after the lock. It is judged blocked only if it returns zero data with the blocked flag set. The same overlap is used for erase followed by verify, which must read zero and not be blocked. For preload, the checks confirm that a refused command leaves the register values exactly as they were.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    typedef enum logic [2:0] {
        OP_CFG_WR  = 3'd0,
        OP_CFG_RD  = 3'd1,
        OP_PRELOAD = 3'd2,
        OP_LOCK    = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_SIG_RD  = 3'd5,
        OP_ERASE   = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_ERASE = 2'd2,
        ST_RESP  = 2'd3
    } st_e;

endpackage

// File: rtl/cfg_word_bank.sv
module cfg_word_bank #(
    parameter int WORDS = 16,
    parameter int W     = 8,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cfg_preload_bank.sv
module cfg_preload_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[g] <= 1'b0;
            end else if (load) begin
                q[g] <= d[g];
            end
        end
    end

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int CFG_WORDS = 16,
    parameter int DATA_W    = 8,
    parameter int SIG_BYTES = 8,
    parameter int NUM_REGS  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(CFG_WORDS)-1:0] cmd_addr,
    input  logic [DATA_W-1:0]            cmd_data,
    output logic                         done,
    output logic [DATA_W-1:0]            rsp_data,
    output logic                         rsp_blocked,
    output logic                         secured,
    output logic [NUM_REGS-1:0]          outreg_q
);

    localparam int ADDR_W = $clog2(CFG_WORDS);
    localparam int SIG_AW = $clog2(SIG_BYTES);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(CFG_WORDS - 1);

    st_e                st_q, st_d;
    op_e                op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic               lock_q;
    logic [ADDR_W-1:0]  wipe_idx_q;
    logic [DATA_W-1:0]  rsp_q;
    logic               blk_q;

    logic               cfg_we;
    logic [ADDR_W-1:0]  cfg_widx;
    logic [DATA_W-1:0]  cfg_wdata;
    logic [DATA_W-1:0]  cfg_rdata;
    logic               sig_we;
    logic [DATA_W-1:0]  sig_rdata;
    logic               pre_load;
    logic               accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cmd_valid) st_d = ST_EXEC;
            ST_EXEC:  st_d = (op_q == OP_ERASE) ? ST_ERASE : ST_RESP;
            ST_ERASE: if (wipe_idx_q == LAST_WORD) st_d = ST_RESP;
            ST_RESP:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs and storage strobes
    always_comb begin
        cmd_ready   = (st_q == ST_IDLE);
        done        = (st_q == ST_RESP);
        rsp_data    = done ? rsp_q : '0;
        rsp_blocked = done & blk_q;
        secured     = lock_q;
        accept      = cmd_valid && (st_q == ST_IDLE);
        cfg_we      = (st_q == ST_ERASE) || ((st_q == ST_EXEC) && (op_q == OP_CFG_WR));
        cfg_widx    = (st_q == ST_ERASE) ? wipe_idx_q : addr_q;
        cfg_wdata   = (st_q == ST_ERASE) ? '0 : data_q;
        sig_we      = (st_q == ST_EXEC) && (op_q == OP_SIG_WR);
        pre_load    = (st_q == ST_EXEC) && (op_q == OP_PRELOAD) && !lock_q;
    end

    // command capture, lock, response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_RSVD;
            addr_q     <= '0;
            data_q     <= '0;
            lock_q     <= 1'b0;
            wipe_idx_q <= '0;
            rsp_q      <= '0;
            blk_q      <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= op_e'(cmd_op);
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
            if (st_q == ST_EXEC) begin
                rsp_q      <= '0;
                blk_q      <= 1'b0;
                wipe_idx_q <= '0;
                unique case (op_q)
                    OP_CFG_RD: begin
                        if (lock_q) blk_q <= 1'b1;
                        else        rsp_q <= cfg_rdata;
                    end
                    OP_PRELOAD: blk_q  <= lock_q;
                    OP_LOCK:    lock_q <= 1'b1;
                    OP_SIG_RD:  rsp_q  <= sig_rdata;
                    OP_CFG_WR, OP_SIG_WR, OP_ERASE, OP_RSVD: ;
                    default: ;
                endcase
            end
            if (st_q == ST_ERASE) begin
                wipe_idx_q <= wipe_idx_q + 1'b1;
                if (wipe_idx_q == LAST_WORD) lock_q <= 1'b0;
            end
        end
    end

    cfg_word_bank #(.WORDS(CFG_WORDS), .W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_widx),
        .wr_data (cfg_wdata),
        .rd_idx  (addr_q),
        .rd_data (cfg_rdata)
    );

    cfg_word_bank #(.WORDS(SIG_BYTES), .W(DATA_W)) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sig_we),
        .wr_idx  (addr_q[SIG_AW-1:0]),
        .wr_data (data_q),
        .rd_idx  (addr_q[SIG_AW-1:0]),
        .rd_data (sig_rdata)
    );

    cfg_preload_bank #(.N(NUM_REGS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pre_load),
        .d     (data_q[NUM_REGS-1:0]),
        .q     (outreg_q)
    );

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [2:0]          cmd_op,
    input logic                done,
    input logic [DATA_W-1:0]   rsp_data,
    input logic                rsp_blocked,
    input logic                secured,
    input logic [NUM_REGS-1:0] outreg_q
);

    logic [2:0] lop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      lop <= 3'd7;
        else if (cmd_valid && cmd_ready) lop <= cmd_op;
    end

    // R1
    a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !done);
    // R1
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != 3'd6) |-> ##2 done);
    // R3
    a_r3_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lop == 3'd3) |-> secured);
    // R4
    a_r4_verify_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lop == 3'd1 && secured) |-> (rsp_blocked && rsp_data == '0));
    // R6
    a_r6_preload_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lop == 3'd2 && secured) |-> (rsp_blocked && $stable(outreg_q)));
    // R7
    a_r7_sig_open: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lop == 3'd5) |-> !rsp_blocked);
    // R8
    a_r8_unlock_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(secured) |-> (done && lop == 3'd6));
    // R9
    a_r9_rsvd_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lop == 3'd7) |-> (rsp_data == '0 && !rsp_blocked && $stable(outreg_q)));

endmodule

bind cfg_guard cfg_guard_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .done        (done),
    .rsp_data    (rsp_data),
    .rsp_blocked (rsp_blocked),
    .secured     (secured),
    .outreg_q    (outreg_q)
);

// File: tb/sim_cfg_guard.sv
module sim_cfg_guard;

    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       done;
    logic [7:0] rsp_data;
    logic       rsp_blocked;
    logic       secured;
    logic [7:0] outreg_q;

    int checks = 0;
    int failures = 0;

    logic [7:0] rd;
    logic       blk;
    int         lat;
    logic       spre;

    always #5 clk = ~clk;

    cfg_guard u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .done(done),
        .rsp_data(rsp_data), .rsp_blocked(rsp_blocked), .secured(secured),
        .outreg_q(outreg_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge of the done cycle
    task automatic do_cmd(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] r, output logic b, output int l, output logic sp);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_data  = d;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        l  = 0;
        sp = secured;
        while (!done) begin
            l++;
            sp = secured;
            @(negedge clk);
        end
        r = rsp_data;
        b = rsp_blocked;
    endtask

    task automatic t_reset;
        chk("R10 ready", cmd_ready, 1);
        chk("R10 done", done, 0);
        chk("R10 secured", secured, 0);
        chk("R10 outreg", outreg_q, 0);
        chk("R10 rsp", rsp_data, 0);
        do_cmd(3'd1, 4'd9, 8'h00, rd, blk, lat, spre);
        chk("R10 cfg word zero", rd, 8'h00);
    endtask

    task automatic t_write_verify;
        do_cmd(3'd0, 4'd5, 8'hA5, rd, blk, lat, spre);
        chk("R1 write latency", lat, 1);
        chk("R1 ready low in done", cmd_ready, 0);
        @(negedge clk);
        chk("R1 done single pulse", done, 0);
        chk("R1 ready back", cmd_ready, 1);
        do_cmd(3'd0, 4'd15, 8'h3C, rd, blk, lat, spre);
        do_cmd(3'd1, 4'd5, 8'h00, rd, blk, lat, spre);
        chk("R2 verify data", rd, 8'hA5);
        chk("R2 verify not blocked", blk, 0);
        chk("R1 verify latency", lat, 1);
        do_cmd(3'd1, 4'd15, 8'h00, rd, blk, lat, spre);
        chk("R2 verify last word", rd, 8'h3C);
    endtask

    task automatic t_preload;
        do_cmd(3'd2, 4'd0, 8'b1010_0110, rd, blk, lat, spre);
        chk("R5 preload value", outreg_q, 8'hA6);
        chk("R5 preload not blocked", blk, 0);
        do_cmd(3'd2, 4'd0, 8'h59, rd, blk, lat, spre);
        chk("R5 preload second value", outreg_q, 8'h59);
    endtask

    task automatic t_reserved;
        do_cmd(3'd7, 4'd5, 8'hFF, rd, blk, lat, spre);
        chk("R9 rsvd latency", lat, 1);
        chk("R9 rsvd data", rd, 0);
        chk("R9 rsvd blocked", blk, 0);
        chk("R9 rsvd outreg kept", outreg_q, 8'h59);
        chk("R9 rsvd secured kept", secured, 0);
        do_cmd(3'd1, 4'd5, 8'h00, rd, blk, lat, spre);
        chk("R9 rsvd cfg kept", rd, 8'hA5);
    endtask

    task automatic t_sig;
        for (int i = 0; i < 8; i++) begin
            do_cmd(3'd4, 4'(i), 8'(i * 17 + 1), rd, blk, lat, spre);
        end
        do_cmd(3'd5, 4'd2, 8'h00, rd, blk, lat, spre);
        chk("R7 sig byte 2", rd, 8'd35);
        do_cmd(3'd5, 4'd7, 8'h00, rd, blk, lat, spre);
        chk("R7 sig byte 7", rd, 8'd120);
        chk("R7 sig not blocked", blk, 0);
    endtask

    task automatic t_lock_then_verify;
        do_cmd(3'd3, 4'd0, 8'h00, rd, blk, lat, spre);
        chk("R3 secured in done cycle", secured, 1);
        chk("R3 unlocked before", spre, 0);
        // next command's valid rises during this done cycle
        do_cmd(3'd1, 4'd5, 8'h00, rd, blk, lat, spre);
        chk("R3 R4 verify after lock data", rd, 0);
        chk("R3 R4 verify after lock blocked", blk, 1);
        chk("R4 blocked latency", lat, 1);
    endtask

    task automatic t_secured_ops;
        do_cmd(3'd2, 4'd0, 8'h0F, rd, blk, lat, spre);
        chk("R6 preload blocked", blk, 1);
        chk("R6 outreg kept", outreg_q, 8'h59);
        do_cmd(3'd5, 4'd2, 8'h00, rd, blk, lat, spre);
        chk("R7 sig read while locked", rd, 8'd35);
        chk("R7 sig read locked not blocked", blk, 0);
        do_cmd(3'd4, 4'd3, 8'hC3, rd, blk, lat, spre);
        do_cmd(3'd5, 4'd3, 8'h00, rd, blk, lat, spre);
        chk("R7 sig write while locked", rd, 8'hC3);
        do_cmd(3'd1, 4'd15, 8'h00, rd, blk, lat, spre);
        chk("R4 second verify blocked", blk, 1);
        chk("R4 second verify data", rd, 0);
    endtask

    task automatic t_erase;
        do_cmd(3'd6, 4'd0, 8'h00, rd, blk, lat, spre);
        chk("R8 erase latency", lat, N + 1);
        chk("R8 locked until done", spre, 1);
        chk("R8 unlocked at done", secured, 0);
        chk("R8 outreg kept", outreg_q, 8'h59);
        do_cmd(3'd1, 4'd5, 8'h00, rd, blk, lat, spre);
        chk("R8 word 5 erased", rd, 0);
        chk("R8 verify open", blk, 0);
        do_cmd(3'd1, 4'd15, 8'h00, rd, blk, lat, spre);
        chk("R8 word 15 erased", rd, 0);
        do_cmd(3'd5, 4'd7, 8'h00, rd, blk, lat, spre);
        chk("R8 sig kept", rd, 8'd120);
        do_cmd(3'd2, 4'd0, 8'h81, rd, blk, lat, spre);
        chk("R8 R5 preload open again", outreg_q, 8'h81);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_verify();
        t_preload();
        t_reserved();
        t_sig();
        t_lock_then_verify();
        t_secured_ops();
        t_erase();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule